// File: doc/BRIEF.md
# Alias-Selected Integrity SRAM Controller

This block is a single-port memory controller with a 32-bit request bus. Behind it sits an array of 64-bit words, and each word has one 8-bit check field. The same physical array appears at four 1 MB windows. The window an access uses decides, on that access alone, how the check field is treated:

- as a SECDED code over the whole 64-bit word;
- as one parity bit per data byte;
- as nothing at all;
- as the data returned by a read.

No configuration register is involved.

Reads take no wait states. The response arrives on the cycle after acceptance, and a single-bit ECC error is corrected on that same cycle. Writes through the ECC window always update only part of the 64-bit word, so they are done as read-modify-write. The old word is read, corrected, merged with the new bytes and re-encoded, which holds the bus for one extra cycle. Error findings are reported as one-cycle pulses alongside the read response.

Top module: `alias_integrity_sram`

## Requirements
- R1: An address hits only when bits [31:22] equal 0x080. On a hit, bits [21:20] select the window: 0 default, 1 parity, 2 unchecked, 3 check-code. A read that misses returns 0 with no error pulse, and a write that misses changes nothing.
- R2: The default window uses SECDED when ECC_EN is set, else parity when PAR_EN is set, else no check. Data written through it reads back unchanged through it.
- R3: A read accepted at clock edge N gives rsp_valid and rsp_rdata during the cycle after N. req_ready stays high across reads. addr[2] selects the upper (1) or lower (0) 32-bit half, and the word index is addr[IDX_W+2:3].
- R4: Every write through an ECC window drives req_ready low for exactly the one cycle after acceptance. The stored word then holds the old word, corrected, with only the byte lanes enabled by req_be replaced. Its check field is re-encoded.
- R5: An ECC read of a word with one flipped bit returns the corrected data and pulses err_corr.
- R6: An ECC read of a word with two flipped bits pulses err_uncorr.
- R7: A parity-window write sets check bit k to the XOR of data byte k, where byte k is bits [8k+7:8k] of the 64-bit word. It changes only the data bytes and check bits of the enabled lanes.
- R8: A parity-window read pulses err_par when any of the four bytes in the addressed half disagrees with its check bit.
- R9: An unchecked-window write changes only the enabled data bytes and leaves the check field unchanged. An unchecked-window read returns the raw data with no error pulse.
- R10: A check-code-window read returns {24'b0, check field}. A write there with req_be[0] set replaces the check field with req_wdata[7:0]; with req_be[0] clear it changes nothing.
- R11: err_corr, err_uncorr and err_par are high only in a rsp_valid cycle, and at most one of them at a time. Writes raise none of them.
- R12: During and after reset, req_ready is 1, and rsp_valid and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address, including the window select |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_corr | output | 1 | Corrected single-bit error pulse |
| err_uncorr | output | 1 | Uncorrectable error pulse |
| err_par | output | 1 | Parity mismatch pulse |

## Verification

Read data and all three error pulses are due exactly one cycle after the edge that accepted the read. req_ready is due low for exactly the one cycle after an ECC write is accepted.

The bench drives inputs shortly after a rising edge and compares the outputs on every falling edge. At each falling edge it compares them with the expectation set at the previous falling edge, then builds the next expectation from the request that the coming edge will accept. A read's expected value is therefore always checked one cycle after its acceptance edge.

Faults are placed through the unchecked window, which lets the bench flip data bits while the check field stays fixed.

// File: rtl/isram_pkg.sv
package isram_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;
    localparam int BUS_W  = 32;
    localparam int BUS_BE = BUS_W / 8;

    typedef enum logic [1:0] {
        MODE_ECC  = 2'd0,
        MODE_PAR  = 2'd1,
        MODE_RAW  = 2'd2,
        MODE_CODE = 2'd3
    } mode_e;

    // Extended Hamming (72,64): data sits at non-power-of-two positions 3..71,
    // bits [6:0] are the Hamming syndrome bits, bit 7 is overall even parity.
    function automatic logic [CHK_W-1:0] secded_code(input logic [DATA_W-1:0] d);
        logic [6:0] h;
        logic [6:0] pv;
        logic [6:0] k;
        h = '0;
        k = '0;
        for (int p = 1; p < WORD_W; p++) begin
            pv = 7'(p);
            if ((pv & (pv - 7'd1)) != 7'd0) begin
                h = h ^ (pv & {7{d[k[5:0]]}});
                k = k + 7'd1;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/isram_alias_decode.sv
module isram_alias_decode
    import isram_pkg::*;
#(
    parameter bit ECC_EN = 1'b1,
    parameter bit PAR_EN = 1'b1,
    parameter int IDX_W  = 8
) (
    input  logic [31:0]      addr,
    output mode_e            mode,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);
    localparam logic [9:0] WIN_TAG   = 10'h080;
    localparam bit         ANY_CHECK = ECC_EN || PAR_EN;
    localparam mode_e      DFLT_MODE = ECC_EN ? MODE_ECC : (PAR_EN ? MODE_PAR : MODE_RAW);
    localparam mode_e      PAR_MODE  = ANY_CHECK ? MODE_PAR : MODE_RAW;

    always_comb begin
        hit   = (addr[31:22] == WIN_TAG);
        idx   = addr[IDX_W+2:3];
        upper = addr[2];
        unique case (addr[21:20])
            2'd0: mode = DFLT_MODE;
            2'd1: mode = PAR_MODE;
            2'd2: mode = MODE_RAW;
            default: begin
                mode = MODE_CODE;
                if (!ANY_CHECK) hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/isram_secded_enc.sv
module isram_secded_enc
    import isram_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  code
);
    always_comb code = secded_code(data);
endmodule

// File: rtl/isram_secded_dec.sv
module isram_secded_dec
    import isram_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [DATA_W-1:0] fixed,
    output logic              single_err,
    output logic              double_err
);
    logic [CHK_W-1:0] fresh;
    logic [6:0]       syn;
    logic             ovr;
    logic [6:0]       pv;
    logic [6:0]       k;

    isram_secded_enc u_enc (.data(data), .code(fresh));

    always_comb begin
        syn        = chk[6:0] ^ fresh[6:0];
        ovr        = ^{data, chk};
        single_err = ovr;
        double_err = !ovr && (syn != 7'd0);
        fixed      = data;
        k          = '0;
        for (int p = 1; p < WORD_W; p++) begin
            pv = 7'(p);
            if ((pv & (pv - 7'd1)) != 7'd0) begin
                fixed[k[5:0]] = data[k[5:0]] ^ (ovr && (syn == pv));
                k = k + 7'd1;
            end
        end
    end
endmodule

// File: rtl/isram_store.sv
module isram_store
    import isram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_bits,
    input  logic [WORD_W-1:0] wr_mask,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= (cells[idx] & ~wr_mask) | (wr_bits & wr_mask);
        if (rd_en) rd_word <= cells[idx];
    end
endmodule

// File: rtl/alias_integrity_sram.sv
module alias_integrity_sram
    import isram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter bit ECC_EN = 1'b1,
    parameter bit PAR_EN = 1'b1,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        err_corr,
    output logic        err_uncorr,
    output logic        err_par
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] r_idx;
        logic             r_upper;
        logic [BUS_W-1:0] r_wdata;
        logic [BUS_BE-1:0] r_be;
        logic             rv;
        mode_e            rmode;
        logic             rhit;
        logic             rupper;
    } ctl_t;

    ctl_t st_q, st_d;

    mode_e             dec_mode;
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_upper;

    logic              mem_re, mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [WORD_W-1:0] wr_bits, wr_mask, rd_word;

    logic [DATA_W-1:0] fixed;
    logic              single_err, double_err;

    logic              sel_upper;
    logic [BUS_W-1:0]  sel_wdata;
    logic [BUS_BE-1:0] sel_be;
    logic [DATA_W-1:0] wide_data, byte_mask, merged;
    logic [LANES-1:0]  wide_be, wr_par, rd_par_bad;
    logic [CHK_W-1:0]  new_code;
    logic              accept;

    isram_alias_decode #(.ECC_EN(ECC_EN), .PAR_EN(PAR_EN), .IDX_W(IDX_W)) u_dec (
        .addr(req_addr), .mode(dec_mode), .hit(dec_hit), .idx(dec_idx), .upper(dec_upper)
    );

    isram_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rd_en(mem_re), .wr_en(mem_we), .idx(mem_idx),
        .wr_bits(wr_bits), .wr_mask(wr_mask), .rd_word(rd_word)
    );

    isram_secded_dec u_chk (
        .data(rd_word[DATA_W-1:0]), .chk(rd_word[WORD_W-1:DATA_W]),
        .fixed(fixed), .single_err(single_err), .double_err(double_err)
    );

    isram_secded_enc u_gen (.data(merged), .code(new_code));

    // Place the 32-bit write on its half of the 64-bit word.
    always_comb begin
        sel_upper = st_q.busy ? st_q.r_upper : dec_upper;
        sel_wdata = st_q.busy ? st_q.r_wdata : req_wdata;
        sel_be    = st_q.busy ? st_q.r_be    : req_be;
        wide_data = sel_upper ? {sel_wdata, 32'h0} : {32'h0, sel_wdata};
        wide_be   = sel_upper ? {sel_be, 4'h0}     : {4'h0, sel_be};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign byte_mask[8*l +: 8] = {8{wide_be[l]}};
        assign wr_par[l]           = ^wide_data[8*l +: 8];
        assign rd_par_bad[l]       = (^rd_word[8*l +: 8]) ^ rd_word[DATA_W+l];
    end

    assign merged    = (fixed & ~byte_mask) | (wide_data & byte_mask);
    assign req_ready = !st_q.busy;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d     = st_q;
        st_d.busy = 1'b0;
        st_d.rv  = 1'b0;
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        mem_idx  = dec_idx;
        wr_bits  = '0;
        wr_mask  = '0;
        if (st_q.busy) begin
            mem_idx = st_q.r_idx;
            mem_we  = 1'b1;
            wr_bits = {new_code, merged};
            wr_mask = '1;
        end else if (req_valid) begin
            if (!req_write) begin
                mem_re      = 1'b1;
                st_d.rv     = 1'b1;
                st_d.rmode  = dec_mode;
                st_d.rhit   = dec_hit;
                st_d.rupper = dec_upper;
            end else if (dec_hit) begin
                unique case (dec_mode)
                    MODE_ECC: begin
                        mem_re        = 1'b1;
                        st_d.busy     = 1'b1;
                        st_d.r_idx    = dec_idx;
                        st_d.r_upper  = dec_upper;
                        st_d.r_wdata  = req_wdata;
                        st_d.r_be     = req_be;
                    end
                    MODE_PAR: begin
                        mem_we  = 1'b1;
                        wr_bits = {wr_par, wide_data};
                        wr_mask = {wide_be, byte_mask};
                    end
                    MODE_RAW: begin
                        mem_we  = 1'b1;
                        wr_bits = {{CHK_W{1'b0}}, wide_data};
                        wr_mask = {{CHK_W{1'b0}}, byte_mask};
                    end
                    default: begin
                        mem_we  = 1'b1;
                        wr_bits = {req_wdata[7:0], {DATA_W{1'b0}}};
                        wr_mask = {{CHK_W{req_be[0]}}, {DATA_W{1'b0}}};
                    end
                endcase
            end
        end
    end

    always_comb begin
        rsp_valid  = st_q.rv;
        rsp_rdata  = '0;
        err_corr   = 1'b0;
        err_uncorr = 1'b0;
        err_par    = 1'b0;
        if (st_q.rhit) begin
            unique case (st_q.rmode)
                MODE_ECC: begin
                    rsp_rdata  = st_q.rupper ? fixed[63:32] : fixed[31:0];
                    err_corr   = st_q.rv && single_err;
                    err_uncorr = st_q.rv && double_err;
                end
                MODE_PAR: begin
                    rsp_rdata = st_q.rupper ? rd_word[63:32] : rd_word[31:0];
                    err_par   = st_q.rv && (st_q.rupper ? |rd_par_bad[7:4] : |rd_par_bad[3:0]);
                end
                MODE_RAW: rsp_rdata = st_q.rupper ? rd_word[63:32] : rd_word[31:0];
                default:  rsp_rdata = {24'h0, rd_word[WORD_W-1:DATA_W]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: an accepted ECC write stalls the next cycle, and only that one
    a_r4_rmw_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && dec_hit && dec_mode == MODE_ECC) |=> !req_ready);
    a_r4_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);
    // R3: read answered on the next cycle, reads never stall
    a_r3_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> rsp_valid);
    a_r3_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
    // R11: error pulses only with a response, and never two at once
    a_r11_flag_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr || err_par) |-> rsp_valid);
    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_corr, err_uncorr, err_par}));
endmodule

// File: tb/tb_alias_integrity_sram.sv
module tb_alias_integrity_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rsp_valid, err_corr, err_uncorr, err_par;
    logic [31:0] rsp_rdata;

    int checks = 0, errs = 0;
    bit run = 0, done = 0;

    always #5 clk = ~clk;

    alias_integrity_sram dut (.*);

    // behavioural model state
    logic [63:0] md [256];
    logic [63:0] er [256];
    bit          eok [256];
    logic [7:0]  mc [256];
    logic [7:0]  mck [256];
    bit          pw [256];

    // expectation for the coming cycle
    bit          e_ready = 1, e_rv = 0, e_dcare = 0, e_learn = 0;
    logic [31:0] e_data = '0;
    logic [2:0]  e_flags = '0, e_fcare = '0;
    string       e_tag = "R3";
    int          e_idx = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] adr(input logic [1:0] seg, input int ix, input bit up);
        return 32'h2000_0000 | (32'(seg) << 20) | (32'(ix) << 3) | (32'(up) << 2);
    endfunction

    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [31:0] a;
            logic [63:0] wd, bm, base;
            int ix, diff;
            bit up, inr;
            logic [1:0] sg;
            chk(req_ready === e_ready, e_ready ? "R3" : "R4", 32'(req_ready), 32'(e_ready));
            chk(rsp_valid === e_rv, "R3", 32'(rsp_valid), 32'(e_rv));
            if (e_rv) begin
                if (e_dcare) chk(rsp_rdata === e_data, e_tag, rsp_rdata, e_data);
                if (e_learn) begin
                    chk(rsp_rdata[31:8] === 24'h0, "R10", rsp_rdata, {24'h0, rsp_rdata[7:0]});
                    mc[e_idx] = rsp_rdata[7:0];
                    mck[e_idx] = 8'hff;
                end
                chk(((({err_corr, err_uncorr, err_par} ^ e_flags) & e_fcare) == 3'b0)
                    && !$isunknown({err_corr, err_uncorr, err_par}),
                    e_tag, 32'({err_corr, err_uncorr, err_par}), 32'(e_flags));
            end else begin
                chk({err_corr, err_uncorr, err_par} === 3'b0, "R11",
                    32'({err_corr, err_uncorr, err_par}), 32'h0);
            end
            // next expectation from the request the coming edge takes
            e_rv = 0; e_ready = 1; e_learn = 0;
            if (req_valid && req_ready) begin
                a = req_addr; inr = (a[31:22] == 10'h080); sg = a[21:20];
                ix = int'(a[10:3]); up = a[2];
                wd = up ? {req_wdata, 32'h0} : {32'h0, req_wdata};
                bm = '0;
                for (int b = 0; b < 4; b++)
                    if (req_be[b]) bm[(up ? 32 : 0) + 8*b +: 8] = 8'hff;
                if (!req_write) begin
                    e_rv = 1; e_dcare = 1; e_flags = 3'b000; e_fcare = 3'b111; e_idx = ix;
                    if (!inr) begin
                        e_data = '0; e_tag = "R1";
                    end else case (sg)
                        2'd0: begin
                            e_tag = "R2";
                            e_data = up ? er[ix][63:32] : er[ix][31:0];
                            diff = $countones(md[ix] ^ er[ix]);
                            if (!eok[ix]) begin e_dcare = 0; e_fcare = 3'b000; end
                            else if (diff == 1) begin e_flags = 3'b100; e_tag = "R5"; end
                            else if (diff >= 2) begin e_flags = 3'b010; e_dcare = 0; e_tag = "R6"; end
                        end
                        2'd1: begin
                            e_tag = "R8";
                            e_data = up ? md[ix][63:32] : md[ix][31:0];
                            for (int b = 0; b < 4; b++) begin
                                int l;
                                l = (up ? 4 : 0) + b;
                                if (!mck[ix][l]) e_fcare[0] = 1'b0;
                                else if ((^md[ix][8*l +: 8]) != mc[ix][l]) e_flags[0] = 1'b1;
                            end
                        end
                        2'd2: begin
                            e_tag = "R9";
                            e_data = up ? md[ix][63:32] : md[ix][31:0];
                        end
                        default: begin
                            e_tag = pw[ix] ? "R7" : "R10";
                            if (mck[ix] == 8'hff) e_data = {24'h0, mc[ix]};
                            else begin e_dcare = 0; e_learn = 1; end
                        end
                    endcase
                end else if (inr) begin
                    case (sg)
                        2'd0: begin
                            e_ready = 0;
                            base = (eok[ix] && $countones(md[ix] ^ er[ix]) <= 1) ? er[ix] : md[ix];
                            md[ix] = (base & ~bm) | (wd & bm);
                            er[ix] = md[ix]; eok[ix] = 1; mck[ix] = 8'h00; pw[ix] = 0;
                        end
                        2'd1: begin
                            md[ix] = (md[ix] & ~bm) | (wd & bm);
                            for (int l = 0; l < 8; l++)
                                if (bm[8*l]) begin
                                    mc[ix][l] = ^md[ix][8*l +: 8];
                                    mck[ix][l] = 1'b1;
                                end
                            eok[ix] = 0; pw[ix] = 1;
                        end
                        2'd2: md[ix] = (md[ix] & ~bm) | (wd & bm);
                        default: if (req_be[0]) begin
                            mc[ix] = req_wdata[7:0]; mck[ix] = 8'hff; eok[ix] = 0; pw[ix] = 0;
                        end
                    endcase
                end
            end
        end
    end

    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        req_valid = 0;
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            md[i] = '0; er[i] = '0; eok[i] = 0; mc[i] = '0; mck[i] = '0; pw[i] = 0;
        end
        repeat (3) begin
            @(negedge clk);
            chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R12", {30'h0, req_ready, rsp_valid}, 32'h2);
            chk({err_corr, err_uncorr, err_par} === 3'b0, "R12", 32'({err_corr, err_uncorr, err_par}), 32'h0);
        end
        rst_n = 1; run = 1;
        @(posedge clk); #2;

        // R2 / R4: ECC writes through default window, back-to-back reads (R3)
        xfer(1, adr(0, 1, 0), 32'h1122_3344, 4'hf);
        xfer(1, adr(0, 1, 1), 32'h5566_7788, 4'hf);
        xfer(0, adr(0, 1, 0), 0, 0);
        xfer(0, adr(0, 1, 1), 0, 0);
        // R4: partial write merges one byte
        xfer(1, adr(0, 1, 1), 32'h0000_AB00, 4'b0010);
        xfer(0, adr(0, 1, 1), 0, 0);
        // learn code, then R9: unchecked flip leaves code alone
        xfer(0, adr(3, 1, 0), 0, 0);
        xfer(0, adr(2, 1, 0), 0, 0);
        xfer(1, adr(2, 1, 0), 32'h1122_3364, 4'hf);
        xfer(0, adr(3, 1, 0), 0, 0);
        // R5: single flip corrected, both halves flag
        xfer(0, adr(0, 1, 0), 0, 0);
        xfer(0, adr(0, 1, 1), 0, 0);
        xfer(0, adr(2, 1, 0), 0, 0);
        // R4: RMW scrubs the single error
        xfer(1, adr(0, 1, 0), 32'h0000_0099, 4'b0001);
        xfer(0, adr(0, 1, 0), 0, 0);
        // R6: double flip
        xfer(1, adr(2, 1, 1), 32'h5467_AB88, 4'hf);
        xfer(0, adr(0, 1, 1), 0, 0);
        // R5: flip in upper half, read lower half
        xfer(1, adr(0, 200, 0), 32'hCAFE_0001, 4'hf);
        xfer(1, adr(0, 200, 1), 32'h0BAD_F00D, 4'hf);
        xfer(1, adr(2, 200, 1), 32'h8BAD_F00D, 4'b1000);
        xfer(0, adr(0, 200, 0), 0, 0);
        // R7 / R8: parity window
        xfer(1, adr(1, 5, 0), 32'hA5A5_0F01, 4'hf);
        xfer(1, adr(1, 5, 1), 32'h8000_7FFF, 4'hf);
        xfer(0, adr(3, 5, 0), 0, 0);
        xfer(0, adr(1, 5, 0), 0, 0);
        xfer(0, adr(1, 5, 1), 0, 0);
        xfer(1, adr(2, 5, 1), 32'h0001_0000, 4'b0100);
        xfer(0, adr(1, 5, 1), 0, 0);
        xfer(0, adr(1, 5, 0), 0, 0);
        xfer(1, adr(1, 5, 1), 32'h0001_0000, 4'b0100);
        xfer(0, adr(3, 5, 0), 0, 0);
        xfer(0, adr(1, 5, 1), 0, 0);
        // R10: code window write and masked write
        xfer(1, adr(3, 5, 0), 32'h0000_00F0, 4'b0001);
        xfer(0, adr(3, 5, 1), 0, 0);
        xfer(0, adr(1, 5, 0), 0, 0);
        xfer(1, adr(3, 5, 0), 32'h0000_0033, 4'b1110);
        xfer(0, adr(3, 5, 0), 0, 0);
        // R1: outside the windows
        xfer(1, 32'h2040_0008, 32'hDEAD_BEEF, 4'hf);
        xfer(0, 32'h1000_0008, 0, 0);
        xfer(0, adr(2, 1, 0), 0, 0);
        idle(4);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule